// File: doc/BRIEF.md
# Single-Lane Float Min/Max Unit with Output Clamp

This block selects between two IEEE-754 single-precision operands in one lane. It offers four selection flavours: minimum, maximum, minimum of magnitudes and maximum of magnitudes. Each flavour has two ways of handling a NaN operand. In the first, the NaN is suppressed and the other operand wins. In the second, the NaN is propagated. An 8-bit opcode picks the flavour and the NaN policy.

A 2-bit output modifier then either passes the selected value through or clamps it to one of three ranges. Each clamp range replaces a NaN with a fixed value.

An opcode outside the supported window marks the output as invalid and forces the result to zero. The datapath is combinational. A parameter adds one register stage at the output, and that stage is on by default.

Top module: `fmm_unit`

## Requirements
- R1: Opcodes 0x28 to 0x2F are accepted and set `valid_o`. Within this window, bit 2 selects max (1) or min (0), bit 1 selects the magnitude forms, and bit 0 selects NaN propagation.
- R2: When neither operand is NaN, min returns the smaller operand and max returns the larger. -0.0 orders below +0.0, and the infinities order as ordinary extremes.
- R3: The magnitude forms clear the sign bit of both operands before comparing them. The returned value therefore has bit 31 clear.
- R4: In the suppressing forms (bit 0 = 0), when exactly one operand is NaN, the result is the other operand.
- R5: In the propagating forms (bit 0 = 1), when exactly one operand is NaN, the result is that NaN with its payload kept. Its sign is cleared in the magnitude forms.
- R6: When both operands are NaN, every form returns 0x7FC00000.
- R7: Modifier 0 passes the selected value unchanged.
- R8: Modifier 1 returns +0.0 for any negative value (including -0.0) and for NaN. Any other value passes unchanged.
- R9: Modifier 2 limits the value to [-1.0, 1.0]: above 1.0 gives 0x3F800000, and below -1.0 gives 0xBF800000. NaN gives 0xBF800000.
- R10: Modifier 3 limits the value to [+0.0, 1.0]: negative values (including -0.0) and NaN give 0x00000000, and values above 1.0 give 0x3F800000.
- R11: An opcode outside 0x28 to 0x2F clears `valid_o` and drives the result to 0, whatever the operands and the modifier.
- R12: With `REGISTERED`=1, the outputs reflect the inputs of the previous rising clock edge. During reset, the outputs hold result 0 and valid 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for the optional output stage |
| rst_ni | input | 1 | Active-low synchronous reset |
| op_a_i | input | 32 | First single-precision operand |
| op_b_i | input | 32 | Second single-precision operand |
| opcode_i | input | 8 | Operation select |
| outmod_i | input | 2 | Output modifier select |
| result_o | output | 32 | Selected and clamped value |
| valid_o | output | 1 | High when the opcode is supported |

## Verification
The bench targets the signed-zero pair, where a plain magnitude compare would let the wrong zero win. It also covers NaN on one side and on both sides, where a design that mixes up the two NaN policies returns the wrong operand or leaks a payload instead of the canonical quiet NaN. Each clamp mode receives a NaN, -0.0 and values beyond ±1.0; a design that confused the replacement constants would show -1.0 where +0.0 belongs, or the reverse. Opcodes just outside the window on both sides must yield zero and a low valid flag, and a one-cycle latency error would show up as results arriving a cycle early.

// File: rtl/fmm_pkg.sv
package fmm_pkg;

    localparam int unsigned FW = 32;

    localparam logic [FW-1:0] CANON_QNAN = 32'h7FC0_0000;
    localparam logic [FW-1:0] POS_ONE    = 32'h3F80_0000;
    localparam logic [FW-1:0] NEG_ONE    = 32'hBF80_0000;
    localparam logic [FW-1:0] POS_ZERO   = 32'h0000_0000;

    typedef enum logic [1:0] {
        OM_PASS  = 2'd0,
        OM_POS   = 2'd1,
        OM_SNORM = 2'd2,
        OM_UNORM = 2'd3
    } outmod_e;

    typedef struct packed {
        logic ok;
        logic is_max;
        logic use_abs;
        logic prop_nan;
    } op_dec_t;

    typedef struct packed {
        logic [FW-1:0] result;
        logic          valid;
    } out_state_t;

    function automatic logic is_nan(input logic [FW-1:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    // Monotonic unsigned key: larger key means larger float, -0 below +0.
    function automatic logic [FW-1:0] order_key(input logic [FW-1:0] x);
        return x[31] ? ~x : {1'b1, x[30:0]};
    endfunction

endpackage

// File: rtl/fmm_decode.sv
module fmm_decode
    import fmm_pkg::*;
#(
    parameter logic [7:0] OP_BASE = 8'h28
) (
    input  logic [7:0] opcode_i,
    output op_dec_t    dec_o
);
    localparam int unsigned SEL_BITS = 3;
    localparam logic [7:0]  BASE_HI  = OP_BASE >> SEL_BITS;

    always_comb begin
        dec_o          = '0;
        dec_o.ok       = (opcode_i[7:SEL_BITS] == BASE_HI[7-SEL_BITS:0]);
        dec_o.is_max   = dec_o.ok & opcode_i[2];
        dec_o.use_abs  = dec_o.ok & opcode_i[1];
        dec_o.prop_nan = dec_o.ok & opcode_i[0];
    end
endmodule

// File: rtl/fmm_pick.sv
module fmm_pick
    import fmm_pkg::*;
(
    input  logic [FW-1:0] a_i,
    input  logic [FW-1:0] b_i,
    input  op_dec_t       dec_i,
    output logic [FW-1:0] pick_o
);
    logic [FW-1:0] a_eff, b_eff;
    logic          a_nan, b_nan, a_below;

    always_comb begin
        a_eff   = dec_i.use_abs ? {1'b0, a_i[FW-2:0]} : a_i;
        b_eff   = dec_i.use_abs ? {1'b0, b_i[FW-2:0]} : b_i;
        a_nan   = is_nan(a_eff);
        b_nan   = is_nan(b_eff);
        a_below = order_key(a_eff) < order_key(b_eff);
        if (a_nan && b_nan) begin
            pick_o = CANON_QNAN;
        end else if (a_nan) begin
            pick_o = dec_i.prop_nan ? a_eff : b_eff;
        end else if (b_nan) begin
            pick_o = dec_i.prop_nan ? b_eff : a_eff;
        end else if (dec_i.is_max) begin
            pick_o = a_below ? b_eff : a_eff;
        end else begin
            pick_o = a_below ? a_eff : b_eff;
        end
    end
endmodule

// File: rtl/fmm_clamp.sv
module fmm_clamp
    import fmm_pkg::*;
(
    input  logic [FW-1:0] x_i,
    input  logic [1:0]    mode_i,
    output logic [FW-1:0] y_o
);
    logic x_nan, x_neg, above_one, below_m1;

    always_comb begin
        x_nan     = is_nan(x_i);
        x_neg     = x_i[FW-1];
        above_one = !x_neg && (x_i[FW-2:0] > POS_ONE[FW-2:0]);
        below_m1  = x_neg && (x_i[FW-2:0] > NEG_ONE[FW-2:0]);
        unique case (outmod_e'(mode_i))
            OM_PASS:  y_o = x_i;
            OM_POS:   y_o = (x_nan || x_neg) ? POS_ZERO : x_i;
            OM_SNORM: y_o = (x_nan || below_m1) ? NEG_ONE
                          : (above_one ? POS_ONE : x_i);
            OM_UNORM: y_o = (x_nan || x_neg) ? POS_ZERO
                          : (above_one ? POS_ONE : x_i);
            default:  y_o = x_i;
        endcase
    end
endmodule

// File: rtl/fmm_unit.sv
module fmm_unit
    import fmm_pkg::*;
#(
    parameter bit         REGISTERED = 1'b1,
    parameter logic [7:0] OP_BASE    = 8'h28
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic [31:0]   op_a_i,
    input  logic [31:0]   op_b_i,
    input  logic [7:0]    opcode_i,
    input  logic [1:0]    outmod_i,
    output logic [31:0]   result_o,
    output logic          valid_o
);
    op_dec_t       dec;
    logic [FW-1:0] picked, clamped;
    out_state_t    state_d, state_q;

    fmm_decode #(.OP_BASE(OP_BASE)) u_dec (
        .opcode_i (opcode_i),
        .dec_o    (dec)
    );

    fmm_pick u_pick (
        .a_i    (op_a_i),
        .b_i    (op_b_i),
        .dec_i  (dec),
        .pick_o (picked)
    );

    fmm_clamp u_clamp (
        .x_i    (picked),
        .mode_i (outmod_i),
        .y_o    (clamped)
    );

    always_comb begin
        state_d        = '0;
        state_d.valid  = dec.ok;
        state_d.result = dec.ok ? clamped : POS_ZERO;
    end

    generate
        if (REGISTERED) begin : g_reg
            always_ff @(posedge clk_i) begin
                if (!rst_ni) state_q <= '0;
                else         state_q <= state_d;
            end

            AST_BAD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (opcode_i[7:3] != OP_BASE[7:3]) |=> (!valid_o && result_o == '0)); // R11
            AST_GOOD_OPCODE: assert property (@(posedge clk_i) disable iff (!rst_ni)
                (opcode_i[7:3] == OP_BASE[7:3]) |=> valid_o); // R1
        end else begin : g_comb
            assign state_q = state_d;
        end
    endgenerate

    assign result_o = state_q.result;
    assign valid_o  = state_q.valid;

    AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec.ok && outmod_i == 2'd0) |-> (clamped == picked)); // R7
    AST_POS_NO_NEG: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (outmod_i == 2'd1) |-> (!clamped[31] && !is_nan(clamped))); // R8
    AST_SNORM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (outmod_i == 2'd2) |-> (!is_nan(clamped) && clamped[30:0] <= POS_ONE[30:0])); // R9
    AST_UNORM_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (outmod_i == 2'd3) |-> (!clamped[31] && clamped <= POS_ONE)); // R10
    AST_DUAL_NAN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec.ok && is_nan(op_a_i) && is_nan(op_b_i)) |-> (picked == CANON_QNAN)); // R6
    AST_ABS_SIGN: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dec.ok && opcode_i[1]) |-> !picked[31]); // R3
endmodule

// File: tb/fmm_unit_tb.sv
module fmm_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] a, b;
    logic [7:0]  opc;
    logic [1:0]  om;
    logic [31:0] res;
    logic        vld;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    fmm_unit dut_i (
        .clk_i    (clk),
        .rst_ni   (rst_n),
        .op_a_i   (a),
        .op_b_i   (b),
        .opcode_i (opc),
        .outmod_i (om),
        .result_o (res),
        .valid_o  (vld)
    );

    // {a, b, opcode, modifier, expected result, expected valid}
    localparam int NV = 28;
    localparam logic [106:0] VEC [NV] = '{
        {32'h3F800000, 32'h40000000, 8'h28, 2'd0, 32'h3F800000, 1'b1}, // R2 min
        {32'h3F800000, 32'h40000000, 8'h2C, 2'd0, 32'h40000000, 1'b1}, // R2 max
        {32'h80000000, 32'h00000000, 8'h28, 2'd0, 32'h80000000, 1'b1}, // R2 -0 min
        {32'h80000000, 32'h00000000, 8'h2C, 2'd0, 32'h00000000, 1'b1}, // R2 +0 max
        {32'hC0000000, 32'h3F800000, 8'h28, 2'd0, 32'hC0000000, 1'b1}, // R2 neg
        {32'hC0000000, 32'h3F800000, 8'h2A, 2'd0, 32'h3F800000, 1'b1}, // R3 absmin
        {32'hC0000000, 32'h3F800000, 8'h2E, 2'd0, 32'h40000000, 1'b1}, // R3 absmax
        {32'h7FC00001, 32'h3F800000, 8'h28, 2'd0, 32'h3F800000, 1'b1}, // R4
        {32'h3F800000, 32'hFFC00005, 8'h2C, 2'd0, 32'h3F800000, 1'b1}, // R4
        {32'h7FA00000, 32'h3F800000, 8'h29, 2'd0, 32'h7FA00000, 1'b1}, // R5
        {32'h3F800000, 32'hFFC00005, 8'h2F, 2'd0, 32'h7FC00005, 1'b1}, // R5 abs
        {32'h7F800001, 32'hFFC00002, 8'h28, 2'd0, 32'h7FC00000, 1'b1}, // R6
        {32'h7F800001, 32'hFFC00002, 8'h2D, 2'd0, 32'h7FC00000, 1'b1}, // R6
        {32'hC0000000, 32'h3F800000, 8'h28, 2'd1, 32'h00000000, 1'b1}, // R8
        {32'h7F800001, 32'hFFC00002, 8'h28, 2'd1, 32'h00000000, 1'b1}, // R8 nan
        {32'h80000000, 32'hBF800000, 8'h2C, 2'd1, 32'h00000000, 1'b1}, // R8 -0
        {32'h40000000, 32'h3F800000, 8'h2C, 2'd2, 32'h3F800000, 1'b1}, // R9 hi
        {32'hC0000000, 32'h3F800000, 8'h28, 2'd2, 32'hBF800000, 1'b1}, // R9 lo
        {32'h7FC00001, 32'h3F800000, 8'h29, 2'd2, 32'hBF800000, 1'b1}, // R9 nan
        {32'h3F000000, 32'h3E800000, 8'h2C, 2'd2, 32'h3F000000, 1'b1}, // R9 in
        {32'h40000000, 32'h3F800000, 8'h2C, 2'd3, 32'h3F800000, 1'b1}, // R10 hi
        {32'hC0000000, 32'h3F800000, 8'h28, 2'd3, 32'h00000000, 1'b1}, // R10 lo
        {32'h7FC00001, 32'h3F800000, 8'h29, 2'd3, 32'h00000000, 1'b1}, // R10 nan
        {32'h3F000000, 32'h3E800000, 8'h2C, 2'd3, 32'h3F000000, 1'b1}, // R10 in
        {32'h80000000, 32'h80000000, 8'h28, 2'd3, 32'h00000000, 1'b1}, // R10 -0
        {32'h3F800000, 32'h40000000, 8'h30, 2'd2, 32'h00000000, 1'b0}, // R11
        {32'h3F800000, 32'h40000000, 8'h27, 2'd1, 32'h00000000, 1'b0}, // R11
        {32'h7F800000, 32'h3F800000, 8'h2C, 2'd0, 32'h7F800000, 1'b1}  // R7 inf
    };

    task automatic check(input string req, input logic [31:0] er, input logic ev);
        checks++;
        if (res !== er || vld !== ev) begin
            fails++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     req, res, vld, er, ev);
        end
    endtask

    function automatic string req_of(input logic [7:0] o, input logic [1:0] m);
        if (o < 8'h28 || o > 8'h2F) return "R11";
        if (m == 2'd1) return "R8";
        if (m == 2'd2) return "R9";
        if (m == 2'd3) return "R10";
        return "R1/R2-R7";
    endfunction

    task automatic drive(input logic [31:0] va, input logic [31:0] vb,
                         input logic [7:0] vo, input logic [1:0] vm);
        @(negedge clk);
        a = va; b = vb; opc = vo; om = vm;
    endtask

    initial begin
        rst_n = 1'b0;
        a = '0; b = '0; opc = 8'h00; om = 2'd0;
        // R12: reset holds zero output even with a valid opcode applied
        drive(32'h3F800000, 32'h40000000, 8'h2C, 2'd0);
        @(negedge clk);
        check("R12 reset", 32'h0, 1'b0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VEC[i][106:75], VEC[i][74:43], VEC[i][42:35], VEC[i][34:33]);
            @(negedge clk);
            check(req_of(VEC[i][42:35], VEC[i][34:33]), VEC[i][32:1], VEC[i][0]);
        end

        // R12: one-cycle latency, output holds previous value until the edge
        drive(32'h3F800000, 32'h40000000, 8'h28, 2'd0);
        @(negedge clk);
        check("R12 settle", 32'h3F800000, 1'b1);
        drive(32'h3F800000, 32'h40000000, 8'h2C, 2'd0);
        #1;
        check("R12 hold", 32'h3F800000, 1'b1);
        @(negedge clk);
        check("R12 update", 32'h40000000, 1'b1);

        // R1: every opcode in the window is accepted, sampled on the boundary ones
        drive(32'h3F800000, 32'h40000000, 8'h2F, 2'd0);
        @(negedge clk);
        check("R1 top of window", 32'h40000000, 1'b1);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: run did not complete");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end
endmodule